// File: doc/BRIEF.md
# Triggered Logic Capture Unit

This block samples the digital outputs of a board under test, all channels at once, and stores each sample in an external byte-wide memory. The block has no conversion stage: every channel is taken as a plain logic level. A controller sets the trigger word, the trigger mode, the sampling period and the number of samples wanted, then pulses `arm`. Capture begins when the trigger condition is met. After that a new sample is taken once per period. Each sample is written to memory as consecutive bytes.

The controller and the capture engine share the memory bus. Two select lines decide who drives it. When both lines are low, the controller's address, data and write strobe pass straight to the memory, and the capture engine stands still. Any other combination gives the bus to the capture engine. When the programmed number of samples has been stored, the block raises an interrupt. The controller then takes the bus back and reads the results one byte at a time through a registered read path.

Top module: `logic_capture`

## Requirements
- R1: After `rst`, `mem_we`, `irq`, `cfg_err` and `mcu_rdata` are 0. While the bus is owned by the capture engine, nothing is written until an accepted arm.
- R2: `cfg_mode` sets the trigger, which is evaluated on the probe inputs registered once (one cycle late):
  - 0 fires in the first owned cycle after arming.
  - 1 fires when the registered inputs equal the trigger word.
  - 2 fires only when the registered inputs equal the word and the previous registered value did not.
- R3: A sample holds all CH_W channels at once. For sample n, byte k (bits 8k+7..8k) is written to address 8n+k. The writes go out one byte per owned cycle, starting the cycle after the sample, with addresses beginning at 0 after each arm. The next sample is taken `cfg_period` owned cycles after the previous one.
- R4: `irq` rises when the last byte of sample number `cfg_depth` is written. It then stays high until `irq_clr` or `arm`.
- R5: When `sel_a`=0 and `sel_b`=0, `mcu_we`, `mcu_addr` and `mcu_wdata` appear on the memory bus one cycle later, and trigger, timer and writer all hold still. Every other select combination hands the bus to the capture engine.
- R6: An arm is refused if any of these holds: `cfg_period` < 8, `cfg_depth` = 0, `cfg_depth` > 2^(ADDR_W-3), or `cfg_mode` = 3. A refused arm sets `cfg_err`, leaves the block idle and performs no capture. An accepted arm clears `cfg_err`.
- R7: An arm during a capture discards pending bytes and clears `irq`. The next capture restarts at address 0 and again stores the full depth.
- R8: Trigger word, mode, period and depth are captured at the accepted arm, and later changes on the config inputs do not affect that capture.
- R9: `mcu_rdata` is a registered copy of `mem_rdata`. With the controller owning the bus, the byte at `mcu_addr` appears two cycles after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_in | input | CH_W | Board-under-test outputs |
| sel_a | input | 1 | Bus select line A |
| sel_b | input | 1 | Bus select line B |
| arm | input | 1 | Pulse: latch config and start waiting for trigger |
| irq_clr | input | 1 | Pulse: clear the interrupt |
| cfg_word | input | CH_W | Trigger word |
| cfg_mode | input | 2 | Trigger mode (0 immediate, 1 equal, 2 enter) |
| cfg_period | input | PER_W | Sampling period in owned cycles |
| cfg_depth | input | DEPTH_W | Samples to store |
| mcu_we | input | 1 | Controller write strobe |
| mcu_addr | input | ADDR_W | Controller memory address |
| mcu_wdata | input | 8 | Controller write byte |
| mcu_rdata | output | 8 | Registered read byte for the controller |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| irq | output | 1 | Depth-reached interrupt |
| cfg_err | output | 1 | Last arm was refused |

## Verification
The hardest situation to reach is the controller taking the bus in the middle of a capture while byte writes are still pending and the period timer is partway through its count. In that case both the writer and the timer must freeze and then resume exactly where they stopped. The stimulus creates this by dropping both select lines a few cycles after an immediate trigger and issuing a controller write inside that window. It then returns ownership through the other select line. A cycle-accurate reference model in the bench predicts every bus cycle, so a single lost or repeated byte shows up at once. A second hard case is the enter trigger with the inputs already equal to the word at arm time: the stimulus holds the word, then steps away from it and back to it.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    TM_NOW   = 2'd0,
    TM_LEVEL = 2'd1,
    TM_ENTER = 2'd2,
    TM_BAD   = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

endpackage

// File: rtl/tcap_trigger.sv
module tcap_trigger
  import tcap_pkg::*;
#(
  parameter int CH_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_W-1:0] probe_q,
  input  logic [CH_W-1:0] word,
  input  trig_mode_e      mode,
  output logic            hit
);

  logic [CH_W-1:0] prev_q;
  logic            now_eq;
  logic            prev_eq;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= probe_q;
  end

  assign now_eq  = (probe_q == word);
  assign prev_eq = (prev_q == word);

  always_comb begin
    case (mode)
      TM_NOW:   hit = 1'b1;
      TM_LEVEL: hit = now_eq;
      TM_ENTER: hit = now_eq && !prev_eq;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/tcap_pacer.sv
module tcap_pacer #(
  parameter int PER_W   = 16,
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               start,
  input  logic               advance,
  input  logic               sample_done,
  input  logic [PER_W-1:0]   period,
  input  logic [DEPTH_W-1:0] depth,
  output logic               take,
  output logic               depth_hit
);

  logic [PER_W-1:0]   tcnt;
  logic [DEPTH_W-1:0] stored;

  assign take      = advance && (tcnt == '0);
  assign depth_hit = sample_done && ((stored + 1'b1) == depth);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      tcnt   <= '0;
      stored <= '0;
    end else begin
      if (start)        tcnt <= period - 1'b1;
      else if (advance) tcnt <= take ? (period - 1'b1) : (tcnt - 1'b1);
      if (sample_done)  stored <= stored + 1'b1;
    end
  end

  // R4: the stored-sample count never passes the latched depth
  assert_stored_le_depth_R4: assert property (@(posedge clk) disable iff (rst)
    stored <= depth);

endmodule

// File: rtl/tcap_writer.sv
module tcap_writer #(
  parameter int CH_W   = 64,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic              enable,
  input  logic [CH_W-1:0]   sample,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_byte,
  output logic              last_byte
);

  localparam int BYTES = CH_W / 8;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [CH_W-1:0]   sbuf;
  logic [IDX_W-1:0]  bidx;
  logic              pend;
  logic [ADDR_W-1:0] wptr;
  logic [7:0]        lane [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane[g] = sbuf[g*8 +: 8];
  end

  assign wr_en     = enable && pend;
  assign last_byte = wr_en && (bidx == IDX_W'(BYTES - 1));
  assign wr_byte   = wr_en ? lane[bidx] : 8'h00;
  assign wr_addr   = wptr;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sbuf <= '0;
      bidx <= '0;
      pend <= 1'b0;
      wptr <= '0;
    end else begin
      if (wr_en) begin
        wptr <= wptr + 1'b1;
        bidx <= bidx + 1'b1;
        if (last_byte) begin
          pend <= 1'b0;
          bidx <= '0;
        end
      end
      if (load) begin
        sbuf <= sample;
        bidx <= '0;
        pend <= 1'b1;
      end
    end
  end

  // R3: a new sample never lands on bytes that are still unwritten
  assert_load_clean_R3: assert property (@(posedge clk) disable iff (rst)
    (load && !flush) |-> (!pend || last_byte));

  // R3: back-to-back byte writes go to consecutive addresses
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wptr == ADDR_W'($past(wptr) + 1'b1)));

endmodule

// File: rtl/tcap_busmux.sv
module tcap_busmux #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [7:0]        eng_data,
  input  logic              mcu_we,
  input  logic [ADDR_W-1:0] mcu_addr,
  input  logic [7:0]        mcu_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [7:0]        mcu_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mcu_rdata <= '0;
    end else begin
      mem_we    <= own ? eng_we   : mcu_we;
      mem_addr  <= own ? eng_addr : mcu_addr;
      mem_wdata <= own ? eng_data : mcu_wdata;
      mcu_rdata <= mem_rdata;
    end
  end

  // R5: with the controller owning the bus, its strobe and address reach memory
  assert_mcu_owns_bus_R5: assert property (@(posedge clk) disable iff (rst)
    !own |=> (mem_we == $past(mcu_we)) && (mem_addr == $past(mcu_addr)));

endmodule

// File: rtl/logic_capture.sv
module logic_capture
  import tcap_pkg::*;
#(
  parameter int CH_W    = 64,
  parameter int ADDR_W  = 18,
  parameter int PER_W   = 16,
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CH_W-1:0]    probe_in,
  input  logic               sel_a,
  input  logic               sel_b,
  input  logic               arm,
  input  logic               irq_clr,
  input  logic [CH_W-1:0]    cfg_word,
  input  logic [1:0]         cfg_mode,
  input  logic [PER_W-1:0]   cfg_period,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic               mcu_we,
  input  logic [ADDR_W-1:0]  mcu_addr,
  input  logic [7:0]         mcu_wdata,
  output logic [7:0]         mcu_rdata,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               irq,
  output logic               cfg_err
);

  localparam int BYTES   = CH_W / 8;
  localparam int BYTE_SH = $clog2(BYTES);
  localparam longint unsigned CAP = 64'd1 << (ADDR_W - BYTE_SH);

  logic [CH_W-1:0]    probe_q;
  logic               own_q;
  logic [CH_W-1:0]    word_q;
  trig_mode_e         mode_q;
  logic [PER_W-1:0]   period_q;
  logic [DEPTH_W-1:0] depth_q;
  cap_state_e         state;

  logic cfg_ok, hit, trig_go, running, take, depth_hit, load;
  logic wr_en, last_byte;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      probe_q <= '0;
      own_q   <= 1'b0;
    end else begin
      probe_q <= probe_in;
      own_q   <= sel_a | sel_b;
    end
  end

  assign cfg_ok = (cfg_mode != TM_BAD) &&
                  (cfg_period >= PER_W'(BYTES)) &&
                  (cfg_depth != '0) &&
                  (64'(cfg_depth) <= CAP);

  assign trig_go = (state == ST_WAIT) && own_q && hit;
  assign running = (state == ST_RUN) && own_q;
  assign load    = trig_go || (take && !depth_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      irq      <= 1'b0;
      cfg_err  <= 1'b0;
      word_q   <= '0;
      mode_q   <= TM_NOW;
      period_q <= '0;
      depth_q  <= '0;
    end else if (arm) begin
      irq     <= 1'b0;
      cfg_err <= !cfg_ok;
      if (cfg_ok) begin
        state    <= ST_WAIT;
        word_q   <= cfg_word;
        mode_q   <= trig_mode_e'(cfg_mode);
        period_q <= cfg_period;
        depth_q  <= cfg_depth;
      end else begin
        state <= ST_IDLE;
      end
    end else begin
      if (trig_go) state <= ST_RUN;
      if (depth_hit) begin
        state <= ST_DONE;
        irq   <= 1'b1;
      end else if (irq_clr) begin
        irq <= 1'b0;
      end
    end
  end

  tcap_trigger #(.CH_W(CH_W)) trig_i (
    .clk(clk), .rst(rst), .probe_q(probe_q), .word(word_q),
    .mode(mode_q), .hit(hit)
  );

  tcap_pacer #(.PER_W(PER_W), .DEPTH_W(DEPTH_W)) pacer_i (
    .clk(clk), .rst(rst), .restart(arm), .start(trig_go),
    .advance(running), .sample_done(last_byte), .period(period_q),
    .depth(depth_q), .take(take), .depth_hit(depth_hit)
  );

  tcap_writer #(.CH_W(CH_W), .ADDR_W(ADDR_W)) writer_i (
    .clk(clk), .rst(rst), .flush(arm), .load(load && !arm),
    .enable(running), .sample(probe_q), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_byte(wr_byte), .last_byte(last_byte)
  );

  tcap_busmux #(.ADDR_W(ADDR_W)) mux_i (
    .clk(clk), .rst(rst), .own(own_q), .eng_we(wr_en),
    .eng_addr(wr_addr), .eng_data(wr_byte), .mcu_we(mcu_we),
    .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mcu_rdata(mcu_rdata)
  );

  // R4: the interrupt holds until cleared or re-armed
  assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr && !arm) |=> irq);

  // R6: a refused configuration leaves the engine idle
  assert_err_idle_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (state == ST_IDLE));

endmodule

// File: tb/logic_capture_tb_top.sv
module logic_capture_tb_top;

  localparam int CH_W = 64, ADDR_W = 18, PER_W = 16, DEPTH_W = 16;

  logic clk = 1'b0;
  logic rst;
  logic [CH_W-1:0] probe_in, cfg_word;
  logic sel_a, sel_b, arm, irq_clr, mcu_we;
  logic [1:0] cfg_mode;
  logic [PER_W-1:0] cfg_period;
  logic [DEPTH_W-1:0] cfg_depth;
  logic [ADDR_W-1:0] mcu_addr, mem_addr;
  logic [7:0] mcu_wdata, mcu_rdata, mem_wdata, mem_rdata;
  logic mem_we, irq, cfg_err;

  always #4 clk = ~clk;

  logic_capture #(.CH_W(CH_W), .ADDR_W(ADDR_W), .PER_W(PER_W), .DEPTH_W(DEPTH_W)) dut_i (
    .clk(clk), .rst(rst), .probe_in(probe_in), .sel_a(sel_a), .sel_b(sel_b),
    .arm(arm), .irq_clr(irq_clr), .cfg_word(cfg_word), .cfg_mode(cfg_mode),
    .cfg_period(cfg_period), .cfg_depth(cfg_depth), .mcu_we(mcu_we),
    .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq), .cfg_err(cfg_err)
  );

  // memory seen by the design
  logic [7:0] sram [4096];
  assign mem_rdata = sram[mem_addr[11:0]];

  int vecs = 0, bad = 0, cyc = 0;
  int wr_cnt = 0;
  int first_addr = -1, last_addr = -1;

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      sram[mem_addr[11:0]] <= mem_wdata;
      if (wr_cnt == 0) first_addr = int'(mem_addr);
      last_addr = int'(mem_addr);
      wr_cnt = wr_cnt + 1;
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [7:0] exp_mem [4096];
  logic [CH_W-1:0] m_pq, m_prev, m_word;
  logic m_own, m_we, m_irq, m_err;
  logic [ADDR_W-1:0] m_addr;
  logic [7:0] m_wd, m_rd;
  int m_state, m_mode, m_per, m_depth, m_tcnt, m_wptr, m_stored;
  logic [7:0] byteq [$];

  always @(posedge clk) begin
    logic eng, hit, done, ok;
    logic n_we; logic [ADDR_W-1:0] n_addr; logic [7:0] n_wd, n_rd;
    if (rst) begin
      m_pq = '0; m_prev = '0; m_word = '0; m_own = 0; m_we = 0; m_irq = 0;
      m_err = 0; m_addr = '0; m_wd = '0; m_rd = '0; m_state = 0; m_mode = 0;
      m_per = 0; m_depth = 0; m_tcnt = 0; m_wptr = 0; m_stored = 0;
      byteq.delete();
    end else begin
      if (m_we) exp_mem[m_addr[11:0]] = m_wd;
      n_rd   = exp_mem[m_addr[11:0]];
      eng    = (m_state == 2) && m_own && (byteq.size() > 0);
      n_we   = m_own ? eng : mcu_we;
      n_addr = m_own ? ADDR_W'(m_wptr) : mcu_addr;
      n_wd   = m_own ? (eng ? byteq[0] : 8'h00) : mcu_wdata;
      done   = 0;
      if (arm) begin
        ok = (cfg_mode != 2'd3) && (cfg_period >= 8) && (cfg_depth != 0) &&
             (int'(cfg_depth) <= (1 << (ADDR_W - 3)));
        m_err = !ok; m_irq = 0; byteq.delete();
        m_wptr = 0; m_stored = 0; m_tcnt = 0;
        if (ok) begin
          m_state = 1; m_word = cfg_word; m_mode = int'(cfg_mode);
          m_per = int'(cfg_period); m_depth = int'(cfg_depth);
        end else m_state = 0;
      end else begin
        case (m_mode)
          0: hit = 1;
          1: hit = (m_pq == m_word);
          2: hit = (m_pq == m_word) && (m_prev != m_word);
          default: hit = 0;
        endcase
        if (m_state == 1 && m_own && hit) begin
          for (int k = 0; k < 8; k++) byteq.push_back(m_pq[k*8 +: 8]);
          m_tcnt = m_per - 1; m_state = 2;
        end else if (m_state == 2 && m_own) begin
          if (eng) begin
            void'(byteq.pop_front());
            m_wptr = m_wptr + 1;
            if (byteq.size() == 0) begin
              m_stored = m_stored + 1;
              if (m_stored == m_depth) done = 1;
            end
          end
          if (done) begin
            m_state = 3; m_irq = 1;
          end else if (m_tcnt == 0) begin
            for (int k = 0; k < 8; k++) byteq.push_back(m_pq[k*8 +: 8]);
            m_tcnt = m_per - 1;
          end else m_tcnt = m_tcnt - 1;
        end
        if (irq_clr && !done) m_irq = 0;
      end
      m_we = n_we; m_addr = n_addr; m_wd = n_wd; m_rd = n_rd;
      m_prev = m_pq; m_pq = probe_in; m_own = sel_a | sel_b;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      vecs = vecs + 1;
      if (mem_we !== m_we || (m_we && (mem_addr !== m_addr || mem_wdata !== m_wd))) begin
        bad = bad + 1;
        $display("FAIL R3/R5 bus cyc=%0d act we=%0b a=%0h d=%0h exp we=%0b a=%0h d=%0h",
                 cyc, mem_we, mem_addr, mem_wdata, m_we, m_addr, m_wd);
      end else if (irq !== m_irq) begin
        bad = bad + 1;
        $display("FAIL R4 irq cyc=%0d act=%0b exp=%0b", cyc, irq, m_irq);
      end else if (cfg_err !== m_err) begin
        bad = bad + 1;
        $display("FAIL R6 cfg_err cyc=%0d act=%0b exp=%0b", cyc, cfg_err, m_err);
      end else if (mcu_rdata !== m_rd) begin
        bad = bad + 1;
        $display("FAIL R9 mcu_rdata cyc=%0d act=%0h exp=%0h", cyc, mcu_rdata, m_rd);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs = vecs + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_arm();
    arm = 1; step(1); arm = 0;
  endtask

  task automatic clr_wr();
    wr_cnt = 0; first_addr = -1; last_addr = -1;
  endtask

  task automatic wait_irq(input int n);
    for (int i = 0; i < n && !irq; i++) step(1);
  endtask

  task automatic setup(input logic [1:0] m, input int per, input int dep);
    cfg_mode = m; cfg_period = PER_W'(per); cfg_depth = DEPTH_W'(dep);
  endtask

  task automatic read_byte(input int a, input logic [7:0] exp, input string tag);
    sel_a = 0; sel_b = 0; mcu_addr = ADDR_W'(a);
    step(3);
    chk(mcu_rdata == exp, tag, mcu_rdata, exp);
  endtask

  localparam logic [63:0] P1 = 64'h0123_4567_89AB_CDEF;

  initial begin
    for (int i = 0; i < 4096; i++) begin sram[i] = 8'h00; exp_mem[i] = 8'h00; end
    rst = 1; probe_in = P1; cfg_word = '0; sel_a = 1; sel_b = 0; arm = 0; irq_clr = 0;
    mcu_we = 0; mcu_addr = '0; mcu_wdata = '0; setup(2'd0, 8, 1);
    step(5); rst = 0; step(3);
    // R1: reset state, no writes before arming
    chk(irq == 0 && cfg_err == 0 && mem_we == 0 && mcu_rdata == 0, "R1 reset", irq, 0);
    chk(wr_cnt == 0, "R1 no writes while idle", wr_cnt, 0);

    // R2/R3/R4: immediate trigger, period 8, depth 3
    setup(2'd0, 8, 3); clr_wr(); pulse_arm(); wait_irq(300);
    chk(irq == 1, "R4 irq at depth", irq, 1);
    chk(wr_cnt == 24, "R3 byte count", wr_cnt, 24);
    chk(last_addr == 23, "R3 last address", last_addr, 23);
    step(10);
    chk(irq == 1, "R4 irq held", irq, 1);
    irq_clr = 1; step(1); irq_clr = 0; step(1);
    chk(irq == 0, "R4 irq cleared", irq, 0);
    // R9: readback, byte k of sample is bits 8k+7..8k
    read_byte(0, 8'hEF, "R9 readback byte0");
    read_byte(7, 8'h01, "R9 readback byte7");
    read_byte(17, 8'hCD, "R9 readback sample2 byte1");
    sel_a = 1; step(2);

    // R2 level mode, R8 latch of trigger word
    probe_in = 64'h1111; cfg_word = 64'hA5A5_0000_0000_5A5A; setup(2'd1, 10, 2);
    clr_wr(); pulse_arm(); step(20);
    chk(wr_cnt == 0, "R2 level no match", wr_cnt, 0);
    cfg_word = 64'h1111; step(20);
    chk(wr_cnt == 0, "R8 later word change ignored", wr_cnt, 0);
    probe_in = 64'hA5A5_0000_0000_5A5A; wait_irq(300);
    chk(wr_cnt == 16, "R2 level trigger stored depth", wr_cnt, 16);
    read_byte(0, 8'h5A, "R9 level readback");
    sel_a = 1; step(2);

    // R2 enter mode: already equal at arm must not fire
    cfg_word = 64'hFEED; probe_in = 64'hFEED; setup(2'd2, 9, 1); step(3);
    clr_wr(); pulse_arm(); step(20);
    chk(wr_cnt == 0, "R2 enter held word", wr_cnt, 0);
    probe_in = 64'hBEEF; step(3); probe_in = 64'hFEED; wait_irq(300);
    chk(wr_cnt == 8, "R2 enter fires on change", wr_cnt, 8);

    // R6: refused configurations
    probe_in = P1;
    setup(2'd0, 7, 2); clr_wr(); pulse_arm(); step(2);
    chk(cfg_err == 1, "R6 short period", cfg_err, 1);
    chk(irq == 0, "R7 arm clears irq", irq, 0);
    setup(2'd0, 8, 0); pulse_arm(); step(2);
    chk(cfg_err == 1, "R6 zero depth", cfg_err, 1);
    setup(2'd0, 8, 40000); pulse_arm(); step(2);
    chk(cfg_err == 1, "R6 depth beyond memory", cfg_err, 1);
    setup(2'd3, 8, 2); pulse_arm(); step(20);
    chk(cfg_err == 1, "R6 bad mode", cfg_err, 1);
    chk(wr_cnt == 0, "R6 no capture after refusal", wr_cnt, 0);
    setup(2'd0, 8, 1); pulse_arm(); step(2);
    chk(cfg_err == 0, "R6 good arm clears", cfg_err, 0);
    wait_irq(300);
    irq_clr = 1; step(1); irq_clr = 0;

    // R5: controller takes the bus mid-capture
    setup(2'd0, 12, 4); pulse_arm(); step(6);
    sel_a = 0; sel_b = 0; step(2); clr_wr();
    step(5);
    mcu_we = 1; mcu_addr = ADDR_W'(100); mcu_wdata = 8'h5A; step(1); mcu_we = 0;
    step(12);
    chk(wr_cnt == 1, "R5 only controller write while frozen", wr_cnt, 1);
    chk(last_addr == 100, "R5 controller address", last_addr, 100);
    sel_b = 1; wait_irq(400);
    chk(irq == 1, "R5 capture resumes to depth", irq, 1);
    sel_b = 0; sel_a = 1;
    read_byte(100, 8'h5A, "R9 controller byte");
    sel_a = 1; step(2);

    // R7: re-arm mid-capture restarts count and address
    setup(2'd0, 8, 6); pulse_arm(); step(15);
    pulse_arm(); clr_wr(); wait_irq(400);
    chk(first_addr == 0, "R7 restart address", first_addr, 0);
    chk(wr_cnt == 48, "R7 full depth after re-arm", wr_cnt, 48);
    step(5);

    summary();
    $finish;
  end

endmodule